// File: doc/BRIEF.md
# Pipelined Character-Cell Video Generator

This block turns a grid of 8-bit character codes into a monochrome raster for a 640x480 display. Two position counters walk the screen. The current position selects a character cell in a text buffer, and the code found there selects a row of an 8-pixel-wide glyph in a glyph memory. A shifter then emits that row one pixel per clock. Both memories are synchronous, and each has a second port that a host uses to load text and glyphs while the display keeps reading.

Every step of the chain is registered, so at most one memory access or one small piece of arithmetic sits between flip-flops. The cost is a fixed latency of six clocks from the counters to the pins. The blank flag and both sync signals pass through a delay line of the same length, so all four outputs describe the same pixel on every clock. All timing values are parameters. Their defaults give 800 clocks per line, 525 lines per frame, 80x30 cells and cells of 8x16 pixels.

Top module: `txtvid_gen`

## Requirements
- R1: The horizontal position counts 0 to H_ACT+H_FP+H_SW+H_BP-1 (default 0 to 799), advancing by one each clock and wrapping to 0, so hsync_o falls exactly once every 800 clocks.
- R2: The vertical position advances only when the horizontal position wraps, and it wraps to 0 after V_ACT+V_FP+V_SW+V_BP lines (default 525), so vsync_o falls once every 800*525 clocks.
- R3: blank_o is 1 for every pixel whose horizontal position is at least H_ACT (640) or whose vertical position is at least V_ACT (480), and 0 otherwise.
- R4: hsync_o is 0 for horizontal positions from H_ACT+H_FP to H_ACT+H_FP+H_SW-1 (656 to 751) and 1 elsewhere. vsync_o is 0 for lines from V_ACT+V_FP to V_ACT+V_FP+V_SW-1 (490 to 491) and 1 elsewhere.
- R5: At a visible pixel (h, v), the block reads the code from text cell (v/CELL_H)*(H_ACT/8) + h/8. The glyph byte it uses sits at glyph address code*CELL_H + (v mod CELL_H), that is {code, line}. pix_o is bit 7-(h mod 8) of that byte, so bit 7 is the leftmost pixel of a cell.
- R6: pix_o is 0 whenever blank_o is 1.
- R7: pix_o, blank_o, hsync_o and vsync_o all describe the same position, six clocks after the counters reach it. After rst_n is released, the first visible pixel (0,0) appears after the 8th rising clock edge: two edges of reset synchronisation, then six pipeline stages.
- R8: A pulse on txt_we stores txt_wdata in cell txt_addr, and a pulse on gly_we stores gly_wdata at glyph address gly_addr. These writes are accepted even while reset is asserted, and frames fetched after the write show the new contents.
- R9: While reset is asserted, blank_o, hsync_o and vsync_o are 1, pix_o is 0, and both counters are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txt_we | input | 1 | Host write strobe for the text buffer |
| txt_addr | input | TXT_AW (12) | Text cell index, row*columns + column |
| txt_wdata | input | 8 | Character code to store |
| gly_we | input | 1 | Host write strobe for the glyph memory |
| gly_addr | input | 8+log2(CELL_H) (12) | Glyph byte address {code, line} |
| gly_wdata | input | 8 | Glyph row, bit 7 leftmost |
| pix_o | output | 1 | Monochrome pixel |
| blank_o | output | 1 | 1 outside the visible area |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
The bench uses reduced timing parameters so that several whole frames fit in the run. It compares every pixel and every control bit against a model built from shadow copies of both memories. Text cells hold the codes 0x00 and 0xFF, which exercise both ends of the glyph address, and a walking single-pixel glyph catches a mirrored bit order or a shifter that loads one pixel early or late. Delaying sync or blank by a different number of stages than the pixel path would show up as a mismatch at the edges of the visible area, and the cycle on which the first visible pixel appears pins the total latency. Text and glyph rewrites made during vertical blanking must show up in the next frame, which catches a write port that drops data or a fetch that addresses the wrong cell.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;
  // glyph row width equals the cell width in pixels
  localparam int unsigned GLYPH_W   = 8;
  localparam int unsigned PH_W      = $clog2(GLYPH_W);
  localparam int unsigned CODE_W    = 8;
  // counter -> address reg -> text read -> code latch -> glyph read
  localparam int unsigned FETCH_LAT = 4;
  // plus shifter stage and output register
  localparam int unsigned PIPE_LAT  = FETCH_LAT + 2;

  typedef struct packed {
    logic blank;
    logic hsync_n;
    logic vsync_n;
  } vid_ctl_t;

  localparam vid_ctl_t CTL_IDLE = '{blank: 1'b1, hsync_n: 1'b1, vsync_n: 1'b1};
endpackage

// File: rtl/txtvid_timing.sv
module txtvid_timing
  import txtvid_pkg::*;
#(
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SW  = 96,
  parameter int unsigned H_BP  = 48,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned V_BP  = 33,
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int unsigned HW    = $clog2(H_TOT),
  localparam int unsigned VW    = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output vid_ctl_t      ctl_o
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACT);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACT);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SW);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SW);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [VW-1:0] vcnt_q, vcnt_d;
  logic          h_wrap;

  // next-state
  always_comb begin
    h_wrap = (hcnt_q == H_LAST);
    hcnt_d = h_wrap ? '0 : hcnt_q + 1'b1;
    vcnt_d = vcnt_q;
    if (h_wrap) begin
      vcnt_d = (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
    end
  end

  // control flags for the current (undelayed) position
  always_comb begin
    ctl_o.blank   = (hcnt_q >= H_VIS) || (vcnt_q >= V_VIS);
    ctl_o.hsync_n = !((hcnt_q >= HS_BEG) && (hcnt_q < HS_END));
    ctl_o.vsync_n = !((vcnt_q >= VS_BEG) && (vcnt_q < VS_END));
  end

  assign hcnt_o = hcnt_q;
  assign vcnt_o = vcnt_q;

endmodule

// File: rtl/txtvid_dpram.sv
module txtvid_dpram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // host write port, guarded against addresses past the array
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  // display read port, registered output
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/txtvid_shifter.sv
module txtvid_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par_i,
  output logic         ser_o
);

  logic [W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = load ? par_i : {sreg_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else begin
      sreg_q <= sreg_d;
    end
  end

  assign ser_o = sreg_q[W-1];

endmodule

// File: rtl/txtvid_gen.sv
module txtvid_gen
  import txtvid_pkg::*;
#(
  parameter int unsigned H_ACT  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SW   = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_ACT  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SW   = 2,
  parameter int unsigned V_BP   = 33,
  parameter int unsigned CELL_H = 16,
  localparam int unsigned COLS      = H_ACT / GLYPH_W,
  localparam int unsigned ROWS      = V_ACT / CELL_H,
  localparam int unsigned TXT_DEPTH = COLS * ROWS,
  localparam int unsigned TXT_AW    = $clog2(TXT_DEPTH),
  localparam int unsigned LINE_W    = $clog2(CELL_H),
  localparam int unsigned GLY_AW    = CODE_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txt_we,
  input  logic [TXT_AW-1:0] txt_addr,
  input  logic [CODE_W-1:0] txt_wdata,
  input  logic              gly_we,
  input  logic [GLY_AW-1:0] gly_addr,
  input  logic [GLYPH_W-1:0] gly_wdata,
  output logic              pix_o,
  output logic              blank_o,
  output logic              hsync_o,
  output logic              vsync_o
);

  localparam int unsigned H_TOT     = H_ACT + H_FP + H_SW + H_BP;
  localparam int unsigned V_TOT     = V_ACT + V_FP + V_SW + V_BP;
  localparam int unsigned HW        = $clog2(H_TOT);
  localparam int unsigned VW        = $clog2(V_TOT);
  localparam int unsigned LINE_STG  = FETCH_LAT - 2;  // aligns with code latch
  localparam int unsigned PH_STG    = FETCH_LAT - 1;  // aligns with glyph row
  localparam int unsigned MASK_STG  = PIPE_LAT - 2;   // blank for output reg
  localparam logic [TXT_AW-1:0] COLS_A = TXT_AW'(COLS);

  // ---------------- reset synchroniser ----------------
  logic rst_meta_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  // ---------------- stage 0: position counters ----------------
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  vid_ctl_t      ctl_c;

  txtvid_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_timing (
    .clk   (clk),
    .rst_n (rst_s_n),
    .hcnt_o(hcnt),
    .vcnt_o(vcnt),
    .ctl_o (ctl_c)
  );

  // ---------------- stage 1: text address register ----------------
  logic [TXT_AW-1:0] col_x, row_x, taddr_d, taddr_q;

  always_comb begin
    col_x   = TXT_AW'(hcnt[HW-1:PH_W]);
    row_x   = TXT_AW'(vcnt[VW-1:LINE_W]);
    taddr_d = ctl_c.blank ? '0 : (row_x * COLS_A + col_x);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      taddr_q <= '0;
    end else begin
      taddr_q <= taddr_d;
    end
  end

  // glyph line and pixel phase travel beside the fetch
  logic [LINE_W-1:0] line_q [FETCH_LAT];
  logic [PH_W-1:0]   ph_q   [FETCH_LAT];

  for (genvar i = 0; i < FETCH_LAT; i++) begin : g_aux
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
          line_q[i] <= '0;
          ph_q[i]   <= '0;
        end else begin
          line_q[i] <= vcnt[LINE_W-1:0];
          ph_q[i]   <= hcnt[PH_W-1:0];
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
          line_q[i] <= '0;
          ph_q[i]   <= '0;
        end else begin
          line_q[i] <= line_q[i-1];
          ph_q[i]   <= ph_q[i-1];
        end
      end
    end
  end

  // ---------------- stage 2: text buffer read ----------------
  logic [CODE_W-1:0] code_raw, code_q;

  txtvid_dpram #(.DEPTH(TXT_DEPTH), .DW(CODE_W), .AW(TXT_AW)) u_text (
    .clk  (clk),
    .we   (txt_we),
    .waddr(txt_addr),
    .wdata(txt_wdata),
    .raddr(taddr_q),
    .rdata(code_raw)
  );

  // ---------------- stage 3: code latch ----------------
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_raw;
    end
  end

  // ---------------- stage 4: glyph memory read ----------------
  logic [GLY_AW-1:0]  graddr;
  logic [GLYPH_W-1:0] gly_row;

  assign graddr = {code_q, line_q[LINE_STG]};

  txtvid_dpram #(.DEPTH(1 << GLY_AW), .DW(GLYPH_W), .AW(GLY_AW)) u_glyph (
    .clk  (clk),
    .we   (gly_we),
    .waddr(gly_addr),
    .wdata(gly_wdata),
    .raddr(graddr),
    .rdata(gly_row)
  );

  // ---------------- stage 5: serialiser ----------------
  logic shf_load, shf_bit;

  assign shf_load = (ph_q[PH_STG] == '0);

  txtvid_shifter #(.W(GLYPH_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_s_n),
    .load (shf_load),
    .par_i(gly_row),
    .ser_o(shf_bit)
  );

  // ---------------- control delay line ----------------
  vid_ctl_t ctl_q [PIPE_LAT];

  for (genvar i = 0; i < PIPE_LAT; i++) begin : g_ctl
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) ctl_q[i] <= CTL_IDLE;
        else          ctl_q[i] <= ctl_c;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) ctl_q[i] <= CTL_IDLE;
        else          ctl_q[i] <= ctl_q[i-1];
      end
    end
  end

  // ---------------- stage 6: output register ----------------
  logic pix_d, pix_q;

  always_comb begin
    pix_d = shf_bit & ~ctl_q[MASK_STG].blank;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pix_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
    end
  end

  assign pix_o   = pix_q;
  assign blank_o = ctl_q[PIPE_LAT-1].blank;
  assign hsync_o = ctl_q[PIPE_LAT-1].hsync_n;
  assign vsync_o = ctl_q[PIPE_LAT-1].vsync_n;

endmodule

// File: rtl/txtvid_chk.sv
module txtvid_chk #(
  parameter int unsigned H_TOT = 800,
  parameter int unsigned V_TOT = 525,
  localparam int unsigned HW = $clog2(H_TOT),
  localparam int unsigned VW = $clog2(V_TOT)
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          pix_o,
  input logic          blank_o,
  input logic          hsync_o,
  input logic          vsync_o
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hcnt != H_LAST) |=> (hcnt == $past(hcnt) + 1'b1)); // R1
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hcnt == H_LAST) |=> (hcnt == '0)); // R1
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hcnt != H_LAST) |=> $stable(vcnt)); // R2
  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hcnt == H_LAST && vcnt != V_LAST) |=> (vcnt == $past(vcnt) + 1'b1)); // R2
  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hcnt == H_LAST && vcnt == V_LAST) |=> (vcnt == '0)); // R2
  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!hsync_o || !vsync_o) |-> blank_o); // R4
  AST_DARK_BLANK: assert property (@(posedge clk) disable iff (!rst_s_n)
    blank_o |-> !pix_o); // R6

endmodule

bind txtvid_gen txtvid_chk #(.H_TOT(H_TOT), .V_TOT(V_TOT)) u_chk (
  .clk    (clk),
  .rst_s_n(rst_s_n),
  .hcnt   (hcnt),
  .vcnt   (vcnt),
  .pix_o  (pix_o),
  .blank_o(blank_o),
  .hsync_o(hsync_o),
  .vsync_o(vsync_o)
);

// File: tb/sim_txtvid_gen.sv
`timescale 1ns/1ps
module sim_txtvid_gen;

  localparam int HA = 64, HF = 4, HS = 8, HB = 4;
  localparam int VA = 32, VF = 2, VS = 2, VB = 3;
  localparam int CH = 16;
  localparam int HT = HA + HF + HS + HB;   // 80
  localparam int VT = VA + VF + VS + VB;   // 39
  localparam int NCOL = HA / 8;
  localparam int NCELL = NCOL * (VA / CH);  // 16
  localparam int FR = HT * VT;
  localparam int TAW = $clog2(NCELL);

  logic clk = 1'b0;
  logic rst_n;
  logic txt_we, gly_we;
  logic [TAW-1:0] txt_addr;
  logic [7:0] txt_wdata, gly_wdata;
  logic [11:0] gly_addr;
  logic pix_o, blank_o, hsync_o, vsync_o;

  always #2 clk = ~clk;

  txtvid_gen #(
    .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB), .CELL_H(CH)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .txt_we(txt_we), .txt_addr(txt_addr), .txt_wdata(txt_wdata),
    .gly_we(gly_we), .gly_addr(gly_addr), .gly_wdata(gly_wdata),
    .pix_o(pix_o), .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  int total = 0, bad = 0, mon_cnt = 0;
  bit done = 0;
  logic [7:0] txt_m [NCELL];
  logic [7:0] gly_m [4096];
  logic [3:0] exp_q [$];   // {pix, blank, hsync, vsync}

  task automatic check_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b item=%0d", tag, act, exp, mon_cnt);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // model of R3 R4 R5 R6 at position (h, v)
  function automatic logic [3:0] exp_at(int h, int v);
    logic blank, hs, vs, pix;
    logic [7:0] code, row;
    blank = (h >= HA) || (v >= VA);
    hs = !((h >= HA + HF) && (h < HA + HF + HS));
    vs = !((v >= VA + VF) && (v < VA + VF + VS));
    pix = 1'b0;
    if (!blank) begin
      code = txt_m[(v / CH) * NCOL + h / 8];
      row  = gly_m[int'(code) * CH + v % CH];
      pix  = row[7 - h % 8];
    end
    return {pix, blank, hs, vs};
  endfunction

  // driver side of the scoreboard: one frame of expectations (R1 R2 wrap order)
  task automatic push_frame();
    for (int v = 0; v < VT; v++)
      for (int h = 0; h < HT; h++)
        exp_q.push_back(exp_at(h, v));
  endtask

  task automatic wr_txt(int a, logic [7:0] d);   // R8
    @(negedge clk);
    txt_we = 1'b1; txt_addr = TAW'(a); txt_wdata = d;
    @(negedge clk);
    txt_we = 1'b0;
    txt_m[a] = d;
  endtask

  task automatic wr_gly(int a, logic [7:0] d);   // R8
    @(negedge clk);
    gly_we = 1'b1; gly_addr = 12'(a); gly_wdata = d;
    @(negedge clk);
    gly_we = 1'b0;
    gly_m[a] = d;
  endtask

  // driver
  initial begin
    rst_n = 1'b0;
    txt_we = 1'b0; gly_we = 1'b0;
    txt_addr = '0; txt_wdata = '0; gly_addr = '0; gly_wdata = '0;
    repeat (3) @(negedge clk);
    // R9: outputs idle while reset is held
    check_bit("R9 blank in reset", blank_o, 1'b1);
    check_bit("R9 hsync in reset", hsync_o, 1'b1);
    check_bit("R9 vsync in reset", vsync_o, 1'b1);
    check_bit("R9 pix in reset", pix_o, 1'b0);
    // R8: loads accepted while reset is asserted
    for (int a = 0; a < 4096; a++) wr_gly(a, 8'((a * 113 + (a >> 5)) ^ 90));
    for (int i = 0; i < NCELL; i++) wr_txt(i, 8'(i * 37 + 11));
    wr_txt(3, 8'hFF);   // top end of glyph address space (R5)
    wr_txt(4, 8'h00);   // bottom end (R5)
    push_frame();
    @(negedge clk);
    rst_n = 1'b1;
    // frame 1 vertical blanking: new text and a walking-pixel glyph (R5 R8)
    wait (mon_cnt >= 34 * HT);
    for (int i = 0; i < NCELL; i++) wr_txt(i, 8'(255 - i * 13));
    for (int l = 0; l < CH; l++) wr_gly(255 * CH + l, 8'(8'h80 >> (l % 8)));
    push_frame();
    // frame 2 vertical blanking: single glyph byte and cell changes (R8)
    wait (mon_cnt >= FR + 34 * HT);
    wr_gly(int'(txt_m[5]) * CH + 3, 8'h01);
    wr_txt(15, 8'h00);
    wr_gly(3, 8'hC3);
    push_frame();
    wait (mon_cnt >= 3 * FR);
    finish_run();
  end

  // monitor side of the scoreboard
  initial begin
    int n, last_hf, last_vf;
    bit aligned;
    logic prev_hs, prev_vs;
    logic [3:0] e;
    n = 0; last_hf = -1; last_vf = -1; aligned = 0;
    prev_hs = 1'b1; prev_vs = 1'b1;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!aligned) begin
        if (blank_o === 1'b0 || n > 40) begin
          aligned = 1;
          check_int("R7 edge of first visible pixel", n, 8);
        end
      end
      if (aligned && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check_bit("R5 pixel", pix_o, e[3]);
        check_bit("R3 blank", blank_o, e[2]);
        check_bit("R4 hsync", hsync_o, e[1]);
        check_bit("R4 vsync", vsync_o, e[0]);
        if (blank_o === 1'b1) check_bit("R6 dark while blank", pix_o, 1'b0);
        if (prev_hs === 1'b1 && hsync_o === 1'b0) begin
          if (last_hf >= 0) check_int("R1 line period", n - last_hf, HT);
          last_hf = n;
        end
        if (prev_vs === 1'b1 && vsync_o === 1'b0) begin
          if (last_vf >= 0) check_int("R2 frame period", n - last_vf, FR);
          last_vf = n;
        end
        prev_hs = hsync_o;
        prev_vs = vsync_o;
        mon_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", mon_cnt, 3 * FR);
    finish_run();
  end

endmodule